// File: doc/BRIEF.md
# Merging Store Queue with Read Bypass

This block sits between a write-through cache and the next level of memory. Processor stores are absorbed into a small queue whose slots are each one cache block wide, so the processor moves on in the cycle its store is taken. Each slot keeps a block address, one valid bit per word and one data word per word position. A store whose block is already waiting in a slot is folded into that slot. The queue then writes its slots to memory one at a time, oldest first, and frees a slot only when memory acknowledges that write.

A read miss from the cache is compared with every waiting slot. If no slot holds its block, the read goes to memory ahead of all queued writes. If a slot does hold its block, the block raises a conflict indication and keeps draining writes in order until no slot matches, and only then issues the read, so a read never returns data older than a queued store. Stores marked as I/O-space accesses are never combined with anything and always get a slot of their own.

Top module: `store_merge_queue`

## Requirements
- R1: When at least one slot is free, a presented store is taken in the same cycle with `st_stall` low.
- R2: `st_stall` is high only when every slot is occupied and the store cannot be merged; a store that can merge is taken even when all slots are occupied.
- R3: A slot is freed only in a cycle where memory acknowledges that slot's write (`mem_ack` with `mem_we` high); while memory withholds acknowledges, a full queue stays full.
- R4: A normal store whose block address (`st_addr[WADDR_W-1:2]`, word index `st_addr[1:0]`) equals that of a waiting, not-yet-issued normal slot writes its word into that slot and sets that word's mask bit; a later store to the same word replaces the earlier value, and the slot reaches memory as one write.
- R5: A store with `st_io` high never merges into a slot, and no store merges into a slot created by an I/O store; a full queue therefore stalls every I/O store.
- R6: Writes leave in arrival order, each as one transaction carrying the slot's block address on `mem_blk`, word k of the block on `mem_wdata[32k+31:32k]`, and the word-valid bits on `mem_wmask` (bit k for word k).
- R7: A read miss whose block matches no waiting slot keeps `rd_conflict` low and is issued as the next memory transaction once the port is free, ahead of any queued write.
- R8: A read miss whose block matches any waiting slot (including one being written) raises `rd_conflict`; writes drain in order through the last matching slot before the read is issued.
- R9: The memory port carries one transaction at a time; `mem_req`, `mem_we`, `mem_blk`, `mem_wdata` and `mem_wmask` hold steady until `mem_ack`, and `rd_done` is high in exactly the cycle a read is acknowledged.
- R10: After reset the queue is empty: `mem_req` low, `st_stall` low, `rd_done` low.
- R11: The slot currently being written to memory accepts no merge; a store to its block while all other slots are occupied stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store present |
| st_addr | input | WADDR_W | Word address of the store; low bits select the word in the block |
| st_data | input | DATA_W | Store data word |
| st_io | input | 1 | Store targets I/O space and must not merge |
| st_stall | output | 1 | Store not taken this cycle |
| rd_req | input | 1 | Read miss pending; held until `rd_done` |
| rd_blk | input | BLK_W | Block address of the read miss |
| rd_conflict | output | 1 | Read block matches a waiting slot |
| rd_done | output | 1 | Read acknowledged by memory this cycle |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Transaction is a write (low for a read) |
| mem_blk | output | BLK_W | Block address of the transaction |
| mem_wdata | output | WORDS*DATA_W | Block write data |
| mem_wmask | output | WORDS | Per-word write enables |
| mem_ack | input | 1 | Memory completes the current transaction |

## Verification
Every non-empty word mask of a block is built by merging (with overwrites) behind a slot held busy at memory, which catches a design that opens a new slot per store, loses earlier words or drops the overwrite. The full-queue cases probe a fresh block, the draining head's block, a mergeable block and an I/O store; a design that stalls too eagerly, merges into the head under transfer, or merges I/O traffic shows the wrong stall or the wrong write sequence. Reads are tried both clear of and overlapping the queue across several memory latencies: a design without bypass puts the read behind the writes, and one without the hazard check issues the read before the matching write has left.

// File: rtl/smq_pkg.sv
`timescale 1ns/1ps
package smq_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_WRITE = 2'd1,
    PORT_READ  = 2'd2
  } port_state_e;
endpackage

// File: rtl/smq_match.sv
`timescale 1ns/1ps
// Compares one probe address against every live slot tag.
module smq_match #(
  parameter int N = 4,
  parameter int W = 26
) (
  input  logic [N-1:0]        live,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        probe,
  output logic [N-1:0]        hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = live[i] && (tags[i] == probe);
  end
endmodule

// File: rtl/smq_port_arb.sv
`timescale 1ns/1ps
// Owns the memory port: one transaction at a time, clean reads first.
module smq_port_arb (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_req,
  input  logic                      rd_conflict,
  input  logic                      have_entry,
  input  logic                      mem_ack,
  output smq_pkg::port_state_e      state_o
);
  import smq_pkg::*;

  port_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PORT_IDLE: begin
        if (rd_req && !rd_conflict) state_d = PORT_READ;
        else if (have_entry)        state_d = PORT_WRITE;
      end
      PORT_WRITE, PORT_READ: begin
        if (mem_ack) state_d = PORT_IDLE;
      end
      default: state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PORT_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/store_merge_queue.sv
`timescale 1ns/1ps
module store_merge_queue #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 28
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   st_valid,
  input  logic [WADDR_W-1:0]                     st_addr,
  input  logic [DATA_W-1:0]                      st_data,
  input  logic                                   st_io,
  output logic                                   st_stall,
  input  logic                                   rd_req,
  input  logic [WADDR_W-$clog2(WORDS)-1:0]       rd_blk,
  output logic                                   rd_conflict,
  output logic                                   rd_done,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [WADDR_W-$clog2(WORDS)-1:0]       mem_blk,
  output logic [WORDS*DATA_W-1:0]                mem_wdata,
  output logic [WORDS-1:0]                       mem_wmask,
  input  logic                                   mem_ack
);
  import smq_pkg::*;

  localparam int OFF_W  = $clog2(WORDS);
  localparam int BLK_W  = WADDR_W - OFF_W;
  localparam int PTR_W  = $clog2(ENTRIES);
  localparam int LINE_W = WORDS * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // slot state
  logic [ENTRIES-1:0]             occ_q, occ_d;
  logic [PTR_W-1:0]               head_q, head_d, tail_q, tail_d;
  logic [ENTRIES-1:0][BLK_W-1:0]  blk_q, blk_d;
  logic [ENTRIES-1:0]             io_q, io_d;
  logic [ENTRIES-1:0][WORDS-1:0]  mask_q, mask_d;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q, data_d;

  port_state_e port_state;
  logic draining;
  assign draining = (port_state == PORT_WRITE);

  logic [BLK_W-1:0] st_blk;
  logic [OFF_W-1:0] st_word;
  assign st_blk  = st_addr[WADDR_W-1:OFF_W];
  assign st_word = st_addr[OFF_W-1:0];

  // merge candidates: occupied, normal, not under transfer
  logic [ENTRIES-1:0] merge_live, merge_hit, rd_hit;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_live
    assign merge_live[i] = occ_q[i] && !io_q[i] &&
                           !(draining && (head_q == PTR_W'(i)));
  end

  smq_match #(.N(ENTRIES), .W(BLK_W)) u_st_match (
    .live(merge_live), .tags(blk_q), .probe(st_blk), .hit(merge_hit));

  smq_match #(.N(ENTRIES), .W(BLK_W)) u_rd_match (
    .live(occ_q), .tags(blk_q), .probe(rd_blk), .hit(rd_hit));

  logic full, can_merge, st_fire, do_merge, do_push, pop;
  assign full        = &occ_q;
  assign can_merge   = !st_io && (|merge_hit);
  assign st_stall    = st_valid && full && !can_merge;
  assign st_fire     = st_valid && !st_stall;
  assign do_merge    = st_fire && can_merge;
  assign do_push     = st_fire && !can_merge;
  assign pop         = draining && mem_ack;
  assign rd_conflict = rd_req && (|rd_hit);

  smq_port_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_req     (rd_req),
    .rd_conflict(rd_conflict),
    .have_entry (|occ_q),
    .mem_ack    (mem_ack),
    .state_o    (port_state)
  );

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  // next state of the queue
  always_comb begin
    occ_d  = occ_q;
    head_d = head_q;
    tail_d = tail_q;
    blk_d  = blk_q;
    io_d   = io_q;
    mask_d = mask_q;
    data_d = data_q;
    if (pop) begin
      occ_d[head_q] = 1'b0;
      head_d        = ptr_inc(head_q);
    end
    if (do_push) begin
      occ_d[tail_q]                            = 1'b1;
      blk_d[tail_q]                            = st_blk;
      io_d[tail_q]                             = st_io;
      mask_d[tail_q]                           = '0;
      mask_d[tail_q][st_word]                  = 1'b1;
      data_d[tail_q][st_word*DATA_W +: DATA_W] = st_data;
      tail_d                                   = ptr_inc(tail_q);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (do_merge && merge_hit[i]) begin
        mask_d[i][st_word]                  = 1'b1;
        data_d[i][st_word*DATA_W +: DATA_W] = st_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      occ_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      occ_q  <= occ_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  // payload flops: no reset, loaded only when a store is taken
  always_ff @(posedge clk) begin
    if (st_fire) begin
      blk_q  <= blk_d;
      io_q   <= io_d;
      mask_q <= mask_d;
      data_q <= data_d;
    end
  end

  // memory port
  assign mem_req   = (port_state != PORT_IDLE);
  assign mem_we    = draining;
  assign mem_blk   = draining ? blk_q[head_q]  : rd_blk;
  assign mem_wdata = draining ? data_q[head_q] : '0;
  assign mem_wmask = draining ? mask_q[head_q] : '0;
  assign rd_done   = (port_state == PORT_READ) && mem_ack;
endmodule

// File: rtl/smq_checker.sv
`timescale 1ns/1ps
module smq_checker #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 26,
  parameter int LINE_W  = 128,
  parameter int WORDS   = 4
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               st_valid,
  input logic               st_io,
  input logic               st_stall,
  input logic               rd_req,
  input logic               rd_conflict,
  input logic               mem_req,
  input logic               mem_we,
  input logic [BLK_W-1:0]   mem_blk,
  input logic [LINE_W-1:0]  mem_wdata,
  input logic [WORDS-1:0]   mem_wmask,
  input logic               mem_ack,
  input logic [ENTRIES-1:0] occ_q
);
  // R2: a stall implies every slot is occupied
  assert_stall_full_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    st_stall |-> (&occ_q));

  // R3: occupancy only drops after a write acknowledge
  assert_release_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($countones(occ_q) < $past($countones(occ_q))) |-> $past(mem_ack && mem_we));

  // R5: an accepted I/O store always takes a fresh slot
  assert_io_new_slot_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_valid && st_io && !st_stall && !(mem_ack && mem_we))
      |=> ($countones(occ_q) == $past($countones(occ_q)) + 1));

  // R7: an idle port with a clean read starts that read next
  assert_read_first_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mem_req && rd_req && !rd_conflict) |=> (mem_req && !mem_we));

  // R8: a read never starts while it overlapped a waiting slot
  assert_read_clean_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(mem_req) && !mem_we) |-> $past(!rd_conflict));

  // R9: the request and its payload hold until acknowledged
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_blk) &&
                               $stable(mem_wdata) && $stable(mem_wmask)));
endmodule

bind store_merge_queue smq_checker #(
  .ENTRIES(ENTRIES),
  .BLK_W  (WADDR_W - $clog2(WORDS)),
  .LINE_W (WORDS * DATA_W),
  .WORDS  (WORDS)
) chk_i (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .st_valid   (st_valid),
  .st_io      (st_io),
  .st_stall   (st_stall),
  .rd_req     (rd_req),
  .rd_conflict(rd_conflict),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_blk    (mem_blk),
  .mem_wdata  (mem_wdata),
  .mem_wmask  (mem_wmask),
  .mem_ack    (mem_ack),
  .occ_q      (occ_q)
);

// File: tb/store_merge_queue_tb_top.sv
`timescale 1ns/1ps
module store_merge_queue_tb_top;
  localparam int WORDS   = 4;
  localparam int DATA_W  = 32;
  localparam int WADDR_W = 28;
  localparam int OFF_W   = 2;
  localparam int BLK_W   = WADDR_W - OFF_W;
  localparam int LINE_W  = WORDS * DATA_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic               st_valid, st_io, st_stall;
  logic [WADDR_W-1:0] st_addr;
  logic [DATA_W-1:0]  st_data;
  logic               rd_req, rd_conflict, rd_done;
  logic [BLK_W-1:0]   rd_blk;
  logic               mem_req, mem_we, mem_ack;
  logic [BLK_W-1:0]   mem_blk;
  logic [LINE_W-1:0]  mem_wdata;
  logic [WORDS-1:0]   mem_wmask;

  store_merge_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_io(st_io),
    .st_stall(st_stall),
    .rd_req(rd_req), .rd_blk(rd_blk), .rd_conflict(rd_conflict), .rd_done(rd_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk(mem_blk), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string msg,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, msg, act, exp);
    end
  endtask

  // memory model and transaction log
  int mem_hold = 1;
  int mem_lat  = 0;
  int wcnt     = 0;
  int log_n    = 0;
  bit ack_was_read = 1'b0;
  logic              log_we   [64];
  logic [BLK_W-1:0]  log_blk  [64];
  logic [LINE_W-1:0] log_data [64];
  logic [WORDS-1:0]  log_mask [64];

  initial begin
    mem_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        if (ack_was_read) rd_req = 1'b0;
      end else if (mem_req && mem_hold == 0) begin
        if (wcnt >= mem_lat) begin
          if (log_n < 64) begin
            log_we[log_n]   = mem_we;
            log_blk[log_n]  = mem_blk;
            log_data[log_n] = mem_wdata;
            log_mask[log_n] = mem_wmask;
            log_n++;
          end
          ack_was_read = !mem_we;
          mem_ack = 1'b1;
          wcnt = 0;
          #1;
          if (ack_was_read)
            chk(rd_done === 1'b1, "R9", "rd_done on read ack", rd_done, 1);
        end else begin
          wcnt++;
        end
      end
    end
  end

  function automatic logic [31:0] dv(input logic [BLK_W-1:0] b, input int w, input int t);
    return {t[7:0], b[15:0], w[7:0]};
  endfunction

  task automatic do_store(input logic [BLK_W-1:0] b, input int w,
                          input logic [31:0] d, input bit io);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {b, w[OFF_W-1:0]}; st_data = d; st_io = io;
    #1;
    while (st_stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0; st_io = 1'b0;
  endtask

  task automatic probe_stall(input logic [BLK_W-1:0] b, input int w, input bit io,
                             output logic s);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {b, w[OFF_W-1:0]}; st_data = '0; st_io = io;
    #1;
    s = st_stall;
    st_valid = 1'b0; st_io = 1'b0;
  endtask

  task automatic wait_log(input int n, input string tag);
    int t = 0;
    while (log_n < n && t < 3000) begin
      @(posedge clk);
      t++;
    end
    if (log_n < n) chk(1'b0, tag, "transaction count", log_n, n);
    repeat (4) @(posedge clk);
  endtask

  task automatic expect_tx(input int i, input bit we, input logic [BLK_W-1:0] b,
                           input logic [WORDS-1:0] m, input logic [LINE_W-1:0] line,
                           input string tag);
    logic [LINE_W-1:0] got;
    got = '0;
    chk(log_we[i] == we && log_blk[i] == b, tag, "kind/block order",
        {log_we[i], log_blk[i]}, {we, b});
    chk(log_mask[i] == m, tag, "word mask", log_mask[i], m);
    for (int k = 0; k < WORDS; k++)
      if (m[k]) got[k*DATA_W +: DATA_W] = log_data[i][k*DATA_W +: DATA_W];
    chk(got == line, tag, "masked data", got, line);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    logic [LINE_W-1:0] line;
    logic [BLK_W-1:0] zb, ab, bb, cb, db;
    st_valid = 1'b0; st_io = 1'b0; st_addr = '0; st_data = '0;
    rd_req = 1'b0; rd_blk = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10: reset state
    chk(mem_req === 1'b0, "R10", "mem_req after reset", mem_req, 0);
    chk(st_stall === 1'b0, "R10", "st_stall after reset", st_stall, 0);
    chk(rd_done === 1'b0, "R10", "rd_done after reset", rd_done, 0);

    // R4/R6: every non-empty word mask, merged behind a busy head slot
    for (int p = 1; p < 16; p++) begin
      log_n = 0; mem_hold = 1; mem_lat = p % 3;
      zb = BLK_W'(26'h100 + p);
      ab = BLK_W'(26'h200 + p);
      line = '0;
      do_store(zb, 0, dv(zb, 0, p), 1'b0);
      for (int w = 0; w < WORDS; w++) begin
        if (p[w]) begin
          do_store(ab, w, dv(ab, w, p ^ 8'h55), 1'b0);
          do_store(ab, w, dv(ab, w, p), 1'b0);
          line[w*DATA_W +: DATA_W] = dv(ab, w, p);
        end
      end
      mem_hold = 0;
      wait_log(2, "R4");
      chk(log_n == 2, "R4", "one write per merged block", log_n, 2);
      expect_tx(0, 1'b1, zb, 4'b0001, {96'd0, dv(zb, 0, p)}, "R6");
      expect_tx(1, 1'b1, ab, p[3:0], line, "R4");
    end

    // R1/R2/R3/R11: full queue behaviour
    log_n = 0; mem_hold = 1; mem_lat = 1;
    probe_stall(BLK_W'(26'h300), 0, 1'b0, s);
    chk(s == 1'b0, "R1", "no stall with free slots", s, 0);
    for (int i = 0; i < 4; i++) do_store(BLK_W'(26'h300 + i), 0, dv(BLK_W'(26'h300 + i), 0, 1), 1'b0);
    probe_stall(BLK_W'(26'h304), 0, 1'b0, s);
    chk(s == 1'b1, "R2", "stall when full and new block", s, 1);
    probe_stall(BLK_W'(26'h300), 1, 1'b0, s);
    chk(s == 1'b1, "R11", "no merge into draining head", s, 1);
    probe_stall(BLK_W'(26'h302), 3, 1'b0, s);
    chk(s == 1'b0, "R2", "merge accepted while full", s, 0);
    do_store(BLK_W'(26'h302), 3, dv(BLK_W'(26'h302), 3, 1), 1'b0);
    repeat (10) @(posedge clk);
    probe_stall(BLK_W'(26'h304), 0, 1'b0, s);
    chk(s == 1'b1, "R3", "slots held without ack", s, 1);
    mem_hold = 0;
    do_store(BLK_W'(26'h304), 0, dv(BLK_W'(26'h304), 0, 1), 1'b0);
    wait_log(5, "R6");
    for (int i = 0; i < 5; i++) begin
      if (i == 2)
        expect_tx(i, 1'b1, BLK_W'(26'h302), 4'b1001,
                  {dv(BLK_W'(26'h302), 3, 1), 64'd0, dv(BLK_W'(26'h302), 0, 1)}, "R6");
      else
        expect_tx(i, 1'b1, BLK_W'(26'h300 + i), 4'b0001,
                  {96'd0, dv(BLK_W'(26'h300 + i), 0, 1)}, "R6");
    end

    // R5: I/O stores take their own slots
    log_n = 0; mem_hold = 1; mem_lat = 0;
    zb = BLK_W'(26'h400); ab = BLK_W'(26'h401);
    do_store(zb, 0, dv(zb, 0, 2), 1'b0);
    do_store(ab, 0, dv(ab, 0, 2), 1'b1);
    do_store(ab, 1, dv(ab, 1, 2), 1'b1);
    do_store(ab, 2, dv(ab, 2, 2), 1'b0);
    probe_stall(ab, 3, 1'b1, s);
    chk(s == 1'b1, "R5", "I/O store never merges", s, 1);
    mem_hold = 0;
    wait_log(4, "R5");
    expect_tx(0, 1'b1, zb, 4'b0001, {96'd0, dv(zb, 0, 2)}, "R5");
    expect_tx(1, 1'b1, ab, 4'b0001, {96'd0, dv(ab, 0, 2)}, "R5");
    expect_tx(2, 1'b1, ab, 4'b0010, {64'd0, dv(ab, 1, 2), 32'd0}, "R5");
    expect_tx(3, 1'b1, ab, 4'b0100, {32'd0, dv(ab, 2, 2), 64'd0}, "R5");

    // R7: clean read bypasses queued writes, across latencies
    for (int lat = 0; lat < 4; lat++) begin
      log_n = 0; mem_hold = 1; mem_lat = lat;
      zb = BLK_W'(26'h500 + lat*16); bb = zb + 1; cb = zb + 2; db = zb + 3;
      do_store(zb, 0, dv(zb, 0, 3), 1'b0);
      do_store(bb, 1, dv(bb, 1, 3), 1'b0);
      do_store(cb, 2, dv(cb, 2, 3), 1'b0);
      @(negedge clk);
      rd_req = 1'b1; rd_blk = db;
      #1;
      chk(rd_conflict === 1'b0, "R7", "no conflict for clean read", rd_conflict, 0);
      mem_hold = 0;
      wait_log(4, "R7");
      expect_tx(0, 1'b1, zb, 4'b0001, {96'd0, dv(zb, 0, 3)}, "R7");
      expect_tx(1, 1'b0, db, 4'b0000, '0, "R7");
      expect_tx(2, 1'b1, bb, 4'b0010, {64'd0, dv(bb, 1, 3), 32'd0}, "R7");
      expect_tx(3, 1'b1, cb, 4'b0100, {32'd0, dv(cb, 2, 3), 64'd0}, "R7");
    end

    // R8: overlapping read waits for its write
    log_n = 0; mem_hold = 1; mem_lat = 1;
    zb = BLK_W'(26'h600); bb = zb + 1; cb = zb + 2; db = zb + 3;
    do_store(zb, 0, dv(zb, 0, 4), 1'b0);
    do_store(bb, 0, dv(bb, 0, 4), 1'b0);
    do_store(cb, 3, dv(cb, 3, 4), 1'b0);
    do_store(db, 0, dv(db, 0, 4), 1'b0);
    @(negedge clk);
    rd_req = 1'b1; rd_blk = cb;
    #1;
    chk(rd_conflict === 1'b1, "R8", "conflict for overlapping read", rd_conflict, 1);
    mem_hold = 0;
    wait_log(5, "R8");
    expect_tx(0, 1'b1, zb, 4'b0001, {96'd0, dv(zb, 0, 4)}, "R8");
    expect_tx(1, 1'b1, bb, 4'b0001, {96'd0, dv(bb, 0, 4)}, "R8");
    expect_tx(2, 1'b1, cb, 4'b1000, {dv(cb, 3, 4), 96'd0}, "R8");
    expect_tx(3, 1'b0, cb, 4'b0000, '0, "R8");
    expect_tx(4, 1'b1, db, 4'b0001, {96'd0, dv(db, 0, 4)}, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule